// File: doc/BRIEF.md
# Banked Memory Address Decoder

This block sits between the CPU of a small 8-bit handheld-style system and its memories. For each bus access it takes the 16-bit address, the access direction and the current bank numbers held in companion registers. It then reports which memory or register block the access targets, the bank index to use inside that target and the offset within the region. Fixed ROM, switchable ROM, two video RAM banks, cartridge RAM, real-time-clock registers, banked work RAM, sprite attribute RAM, sound registers, high RAM, the interrupt-enable register and the general I/O block are all decoded. The block holds none of these memories. It only steers the access, so any downstream storage can be attached.

The echo area is folded onto work RAM before the address is decoded. Writes into the ROM space are steered to the bank controller and never to ROM. Some reads have no backing store: cartridge RAM while it is disabled, and the unused tail of the sprite area. These reads are flagged as open-bus and come with the value 0xFF. Writes to the same places select nothing. The decode result is registered once, so the block adds one cycle to the access path.

Top module: `bank_addr_decoder`

## Requirements
- R1: A request presented with `req_valid` high produces its result on the outputs exactly one clock cycle later, with `out_valid` high. `out_region` has at most one bit set, with this bit order: 0 fixed ROM, 1 switchable ROM, 2 bank controller, 3 video RAM, 4 cartridge RAM, 5 clock register, 6 work RAM, 7 sprite RAM, 8 sound, 9 high RAM, 10 interrupt enable, 11 I/O, 12 open bus. With no request, `out_valid` is low and `out_region`, `out_bank`, `out_offset` and `out_fixed_data` are all zero, which is also the reset state.
- R2: Reads of 0x0000–0x3FFF select fixed ROM with bank 0. Reads of 0x4000–0x7FFF select switchable ROM with bank `rom_bank`. Both use offset addr[13:0].
- R3: Any write to 0x0000–0x7FFF selects the bank controller with bank 0 and offset addr[14:0], and never a ROM region.
- R4: Addresses 0x8000–0x9FFF select video RAM with bank `vram_bank` and offset addr[12:0].
- R5: Addresses 0xA000–0xBFFF select cartridge RAM, with bank `cram_bank` and offset addr[12:0], when `cram_en` is high and `rtc_sel[3]` is low. When `cram_en` is low, a read selects open bus with `out_fixed_data` 0xFF, and a write selects no region.
- R6: When `cram_en` is high and `rtc_sel[3]` is high, addresses 0xA000–0xBFFF select the clock register, with bank `rtc_sel[2:0]` and offset 0.
- R7: Addresses 0xC000–0xCFFF select work RAM bank 0. Addresses 0xD000–0xDFFF select work RAM bank `wram_bank`, where a value of 0 selects bank 1. Both use offset addr[11:0].
- R8: Reads and writes of 0xE000–0xFDFF decode exactly like the same address with bit 13 cleared.
- R9: Addresses 0xFE00–0xFE9F select sprite RAM with offset addr[7:0]. A read of 0xFEA0–0xFEFF selects open bus with `out_fixed_data` 0xFF, and a write there selects no region.
- R10: Addresses 0xFF10–0xFF3F select sound with offset addr[7:0]. Addresses 0xFF80–0xFFFE select high RAM with offset addr[6:0]. Address 0xFFFF selects interrupt enable with offset 0. Every other 0xFFxx address selects I/O with offset addr[7:0]. All of these use bank 0.
- R11: `out_fixed_data` is 0xFF exactly when the open-bus bit is set, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | CPU address |
| rom_bank | input | ROM_BANK_W | Selected switchable ROM bank |
| vram_bank | input | 1 | Video RAM bank select |
| cram_en | input | 1 | Cartridge RAM enable |
| cram_bank | input | CRAM_BANK_W | Cartridge RAM bank |
| rtc_sel | input | 4 | Clock-register select (bit 3 routes to clock, bits 2:0 index) |
| wram_bank | input | 3 | Upper work RAM bank register |
| out_valid | output | 1 | Result valid |
| out_region | output | 13 | One-hot region select |
| out_bank | output | ROM_BANK_W | Bank index within region |
| out_offset | output | 15 | Offset within region |
| out_fixed_data | output | 8 | Open-bus read value |

## Verification
Every result is due on the rising edge that follows the cycle in which its request was driven. The bench drives each request at a falling edge and holds it across one rising edge. It then compares the outputs at the next falling edge, half a period after they settle. A queue holds the expected results in issue order, one entry per request, and the monitor removes one entry for each valid output. Idle cycles between requests are checked for all-zero outputs, which shows that no stale result is left on the outputs.

// File: rtl/bad_pkg.sv
package bad_pkg;
    localparam int ADDR_W   = 16;
    localparam int OFF_W    = ADDR_W - 1;
    localparam int N_REGION = 13;

    typedef enum logic [3:0] {
        RG_ROM0 = 4'd0,
        RG_ROMX = 4'd1,
        RG_BCTL = 4'd2,
        RG_VRAM = 4'd3,
        RG_CRAM = 4'd4,
        RG_CLKR = 4'd5,
        RG_WRAM = 4'd6,
        RG_OAM  = 4'd7,
        RG_SND  = 4'd8,
        RG_HRAM = 4'd9,
        RG_IE   = 4'd10,
        RG_IO   = 4'd11,
        RG_OPEN = 4'd12,
        RG_NONE = 4'd13
    } region_e;

    localparam logic [7:0] OPEN_BUS_VALUE = 8'hFF;
endpackage

// File: rtl/bad_echo_fold.sv
module bad_echo_fold
    import bad_pkg::*;
(
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out
);
    logic in_echo;

    // echo window: top three bits set, but below the FExx/FFxx page pair
    always_comb begin
        in_echo  = (addr_in[15:13] == 3'b111) && (addr_in[15:9] != 7'b1111111);
        addr_out = addr_in;
        if (in_echo) begin
            addr_out[13] = 1'b0;
        end
    end
endmodule

// File: rtl/bad_classify.sv
module bad_classify
    import bad_pkg::*;
#(
    parameter int ROM_BANK_W  = 9,
    parameter int CRAM_BANK_W = 4
) (
    input  logic [ADDR_W-1:0]      addr,
    input  logic                   is_write,
    input  logic [ROM_BANK_W-1:0]  rom_bank,
    input  logic                   vram_bank,
    input  logic                   cram_en,
    input  logic [CRAM_BANK_W-1:0] cram_bank,
    input  logic [3:0]             rtc_sel,
    input  logic [2:0]             wram_bank,
    output region_e                region,
    output logic [ROM_BANK_W-1:0]  bank,
    output logic [OFF_W-1:0]       offset
);
    logic [7:0] lo;
    logic       top_page;
    logic       ff_page;
    logic [2:0] wram_eff;

    assign lo       = addr[7:0];
    assign top_page = (addr[15:9] == 7'b1111111);
    assign ff_page  = addr[8];
    assign wram_eff = (wram_bank == 3'd0) ? 3'd1 : wram_bank;

    always_comb begin
        region = RG_NONE;
        bank   = '0;
        offset = '0;
        unique case (addr[15:13])
            3'b000, 3'b001: begin
                if (is_write) begin
                    region = RG_BCTL;
                    offset = addr[14:0];
                end else begin
                    region = RG_ROM0;
                    offset = OFF_W'(addr[13:0]);
                end
            end
            3'b010, 3'b011: begin
                if (is_write) begin
                    region = RG_BCTL;
                    offset = addr[14:0];
                end else begin
                    region = RG_ROMX;
                    bank   = rom_bank;
                    offset = OFF_W'(addr[13:0]);
                end
            end
            3'b100: begin
                region = RG_VRAM;
                bank   = ROM_BANK_W'(vram_bank);
                offset = OFF_W'(addr[12:0]);
            end
            3'b101: begin
                if (!cram_en) begin
                    region = is_write ? RG_NONE : RG_OPEN;
                end else if (rtc_sel[3]) begin
                    region = RG_CLKR;
                    bank   = ROM_BANK_W'(rtc_sel[2:0]);
                end else begin
                    region = RG_CRAM;
                    bank   = ROM_BANK_W'(cram_bank);
                    offset = OFF_W'(addr[12:0]);
                end
            end
            3'b110: begin
                region = RG_WRAM;
                bank   = addr[12] ? ROM_BANK_W'(wram_eff) : '0;
                offset = OFF_W'(addr[11:0]);
            end
            default: begin
                if (!top_page) begin
                    region = RG_NONE;
                end else if (!ff_page) begin
                    if (lo < 8'hA0) begin
                        region = RG_OAM;
                        offset = OFF_W'(lo);
                    end else begin
                        region = is_write ? RG_NONE : RG_OPEN;
                    end
                end else if (lo == 8'hFF) begin
                    region = RG_IE;
                end else if (lo[7]) begin
                    region = RG_HRAM;
                    offset = OFF_W'(lo[6:0]);
                end else if (lo >= 8'h10 && lo <= 8'h3F) begin
                    region = RG_SND;
                    offset = OFF_W'(lo);
                end else begin
                    region = RG_IO;
                    offset = OFF_W'(lo);
                end
            end
        endcase
    end
endmodule

// File: rtl/bank_addr_decoder.sv
module bank_addr_decoder
    import bad_pkg::*;
#(
    parameter int ROM_BANK_W  = 9,
    parameter int CRAM_BANK_W = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic                   req_write,
    input  logic [15:0]            req_addr,
    input  logic [ROM_BANK_W-1:0]  rom_bank,
    input  logic                   vram_bank,
    input  logic                   cram_en,
    input  logic [CRAM_BANK_W-1:0] cram_bank,
    input  logic [3:0]             rtc_sel,
    input  logic [2:0]             wram_bank,
    output logic                   out_valid,
    output logic [12:0]            out_region,
    output logic [ROM_BANK_W-1:0]  out_bank,
    output logic [14:0]            out_offset,
    output logic [7:0]             out_fixed_data
);
    logic [ADDR_W-1:0]     folded;
    region_e               dec_region;
    logic [ROM_BANK_W-1:0] dec_bank;
    logic [OFF_W-1:0]      dec_off;

    logic                  valid_q;
    region_e               region_q;
    logic [ROM_BANK_W-1:0] bank_q;
    logic [OFF_W-1:0]      off_q;

    bad_echo_fold u_fold (
        .addr_in  (req_addr),
        .addr_out (folded)
    );

    bad_classify #(
        .ROM_BANK_W  (ROM_BANK_W),
        .CRAM_BANK_W (CRAM_BANK_W)
    ) u_classify (
        .addr      (folded),
        .is_write  (req_write),
        .rom_bank  (rom_bank),
        .vram_bank (vram_bank),
        .cram_en   (cram_en),
        .cram_bank (cram_bank),
        .rtc_sel   (rtc_sel),
        .wram_bank (wram_bank),
        .region    (dec_region),
        .bank      (dec_bank),
        .offset    (dec_off)
    );

    // result register: one stage between bus and memories
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q  <= 1'b0;
            region_q <= RG_NONE;
            bank_q   <= '0;
            off_q    <= '0;
        end else if (req_valid) begin
            valid_q  <= 1'b1;
            region_q <= dec_region;
            bank_q   <= dec_bank;
            off_q    <= dec_off;
        end else begin
            valid_q  <= 1'b0;
            region_q <= RG_NONE;
            bank_q   <= '0;
            off_q    <= '0;
        end
    end

    genvar gi;
    generate
        for (gi = 0; gi < N_REGION; gi++) begin : g_onehot
            assign out_region[gi] = valid_q && (region_q == region_e'(gi));
        end
    endgenerate

    always_comb begin
        out_valid      = valid_q;
        out_bank       = bank_q;
        out_offset     = off_q;
        out_fixed_data = (valid_q && region_q == RG_OPEN) ? OPEN_BUS_VALUE : 8'h00;
    end

    // R1: at most one target per access, nothing selected when idle
    a_r1_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(out_region));
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (out_region == '0) && !out_valid);

    // R3: ROM-space writes reach the bank controller
    a_r3_rom_write_steer: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !req_addr[15]) |=> out_region[2] && !out_region[0] && !out_region[1]);

    // R5: disabled cartridge RAM reads give the open-bus value
    a_r5_cram_off_read: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_addr[15:13] == 3'b101 && !cram_en)
        |=> out_region[12] && (out_fixed_data == 8'hFF));

    // R7: upper work RAM window never lands on bank 0
    a_r7_wram_bank_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr[15:12] == 4'hD) |=> out_region[6] && (out_bank != '0));

    // R9: writes to the sprite-area tail select nothing
    a_r9_oam_tail_write: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_addr[15:8] == 8'hFE && req_addr[7:0] >= 8'hA0)
        |=> out_valid && (out_region == '0));

    // R11: open-bus value appears only with the open-bus select
    a_r11_fixed_data: assert property (@(posedge clk) disable iff (!rst_n)
        (out_fixed_data != 8'h00) |-> out_region[12]);
endmodule

// File: tb/tb_bank_addr_decoder.sv
module tb_bank_addr_decoder;
    localparam int RBW = 9;
    localparam int CBW = 4;

    typedef struct {
        int    ridx;
        int    bank;
        int    off;
        string tag;
    } exp_t;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           req_valid = 1'b0;
    logic           req_write = 1'b0;
    logic [15:0]    req_addr = '0;
    logic [RBW-1:0] rom_bank = 9'd1;
    logic           vram_bank = 1'b0;
    logic           cram_en = 1'b0;
    logic [CBW-1:0] cram_bank = '0;
    logic [3:0]     rtc_sel = '0;
    logic [2:0]     wram_bank = '0;
    logic           out_valid;
    logic [12:0]    out_region;
    logic [RBW-1:0] out_bank;
    logic [14:0]    out_offset;
    logic [7:0]     out_fixed_data;

    int   n_checks = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    exp_t sb[$];

    always #4 clk = ~clk;

    bank_addr_decoder #(.ROM_BANK_W(RBW), .CRAM_BANK_W(CBW)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .rom_bank(rom_bank), .vram_bank(vram_bank),
        .cram_en(cram_en), .cram_bank(cram_bank), .rtc_sel(rtc_sel),
        .wram_bank(wram_bank), .out_valid(out_valid), .out_region(out_region),
        .out_bank(out_bank), .out_offset(out_offset), .out_fixed_data(out_fixed_data)
    );

    // expected result from the requirement text
    function automatic exp_t model(bit w, logic [15:0] a0);
        exp_t e;
        logic [15:0] a;
        a = a0;
        e.ridx = -1; e.bank = 0; e.off = 0; e.tag = "";
        if (a >= 16'hE000 && a <= 16'hFDFF) begin
            a = a & 16'hDFFF;
            e.tag = "R8 ";
        end
        if (a < 16'h8000 && w) begin
            e.ridx = 2; e.off = a & 16'h7FFF; e.tag = {e.tag, "R3"};
        end else if (a < 16'h4000) begin
            e.ridx = 0; e.off = a & 16'h3FFF; e.tag = {e.tag, "R2"};
        end else if (a < 16'h8000) begin
            e.ridx = 1; e.bank = rom_bank; e.off = a & 16'h3FFF; e.tag = {e.tag, "R2"};
        end else if (a < 16'hA000) begin
            e.ridx = 3; e.bank = vram_bank; e.off = a & 16'h1FFF; e.tag = {e.tag, "R4"};
        end else if (a < 16'hC000) begin
            if (!cram_en) begin
                e.ridx = w ? -1 : 12; e.tag = {e.tag, "R5"};
            end else if (rtc_sel[3]) begin
                e.ridx = 5; e.bank = rtc_sel[2:0]; e.tag = {e.tag, "R6"};
            end else begin
                e.ridx = 4; e.bank = cram_bank; e.off = a & 16'h1FFF; e.tag = {e.tag, "R5"};
            end
        end else if (a < 16'hD000) begin
            e.ridx = 6; e.off = a & 16'h0FFF; e.tag = {e.tag, "R7"};
        end else if (a < 16'hE000) begin
            e.ridx = 6; e.bank = (wram_bank == 0) ? 1 : wram_bank;
            e.off = a & 16'h0FFF; e.tag = {e.tag, "R7"};
        end else if (a < 16'hFEA0) begin
            e.ridx = 7; e.off = a & 16'h00FF; e.tag = {e.tag, "R9"};
        end else if (a < 16'hFF00) begin
            e.ridx = w ? -1 : 12; e.tag = {e.tag, "R9"};
        end else if (a == 16'hFFFF) begin
            e.ridx = 10; e.tag = {e.tag, "R10"};
        end else if (a >= 16'hFF80) begin
            e.ridx = 9; e.off = a & 16'h007F; e.tag = {e.tag, "R10"};
        end else if (a >= 16'hFF10 && a <= 16'hFF3F) begin
            e.ridx = 8; e.off = a & 16'h00FF; e.tag = {e.tag, "R10"};
        end else begin
            e.ridx = 11; e.off = a & 16'h00FF; e.tag = {e.tag, "R10"};
        end
        return e;
    endfunction

    task automatic check(bit ok, string tag, string what, int act, int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, expv);
        end
    endtask

    // driver: hold each request across exactly one rising edge
    task automatic issue(bit w, logic [15:0] a);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = w;
        req_addr  = a;
        sb.push_back(model(w, a));
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
        req_write = 1'b0;
        @(posedge clk);
        #1;
    endtask

    // monitor: compare half a cycle after the result edge
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && !done) begin
                if (out_valid) begin
                    if (sb.size() == 0) begin
                        check(1'b0, "R1", "unexpected result", 1, 0);
                    end else begin
                        exp_t e;
                        logic [12:0] xr;
                        e  = sb.pop_front();
                        xr = (e.ridx < 0) ? 13'd0 : (13'd1 << e.ridx);
                        check(out_region == xr, {e.tag, " R1"}, "region", out_region, xr);
                        check(out_bank == e.bank[RBW-1:0], e.tag, "bank", out_bank, e.bank);
                        check(out_offset == e.off[14:0], e.tag, "offset", out_offset, e.off);
                        check(out_fixed_data == ((e.ridx == 12) ? 8'hFF : 8'h00), "R11",
                              "fixed data", out_fixed_data, (e.ridx == 12) ? 8'hFF : 8'h00);
                    end
                end else begin
                    check(out_region == 0 && out_fixed_data == 0 && out_bank == 0 && out_offset == 0,
                          "R1", "idle outputs", out_region, 0);
                end
            end
        end
    end

    initial begin
        #200000;
        check(1'b0, "R1", "watchdog expired", 0, 1);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check(out_valid == 0 && out_region == 0 && out_fixed_data == 0, "R1", "reset state",
              out_region, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;

        // R2 ROM reads
        rom_bank = 9'h1A5;
        issue(0, 16'h0000);
        issue(0, 16'h3FFF);
        issue(0, 16'h4000);
        issue(0, 16'h7ABC);
        idle();
        // R3 ROM-space writes
        issue(1, 16'h2000);
        issue(1, 16'h4123);
        issue(1, 16'h7FFF);
        // R4 video RAM
        vram_bank = 1'b1;
        issue(0, 16'h9F00);
        vram_bank = 1'b0;
        issue(1, 16'h8001);
        // R5 cartridge RAM
        cram_en = 1'b1; cram_bank = 4'd3;
        issue(0, 16'hA123);
        issue(1, 16'hBFFF);
        cram_en = 1'b0;
        issue(0, 16'hA000);
        issue(1, 16'hB555);
        // R6 clock register
        cram_en = 1'b1; rtc_sel = 4'hD;
        issue(0, 16'hA777);
        issue(1, 16'hBF00);
        cram_en = 1'b0;
        issue(0, 16'hA010);
        rtc_sel = 4'h0;
        idle();
        // R7 work RAM
        issue(0, 16'hC005);
        wram_bank = 3'd0;
        issue(0, 16'hD00F);
        wram_bank = 3'd5;
        issue(1, 16'hDFFF);
        wram_bank = 3'd7;
        issue(0, 16'hD800);
        // R8 echo
        wram_bank = 3'd0;
        issue(0, 16'hE010);
        issue(1, 16'hF234);
        wram_bank = 3'd6;
        issue(0, 16'hFDFF);
        // R9 sprite RAM
        issue(1, 16'hFE00);
        issue(0, 16'hFE9F);
        issue(0, 16'hFEA0);
        issue(1, 16'hFEFF);
        // R10 high page
        issue(0, 16'hFF00);
        issue(0, 16'hFF0F);
        issue(1, 16'hFF10);
        issue(0, 16'hFF3F);
        issue(0, 16'hFF40);
        issue(0, 16'hFF7F);
        issue(1, 16'hFF80);
        issue(0, 16'hFFFE);
        issue(0, 16'hFFFF);
        idle();
        idle();
        check(sb.size() == 0, "R1", "pending results", sb.size(), 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule